// File: doc/BRIEF.md
# Double-Buffered 16-bit Output Compare Channel

This block is one compare channel of a 16-bit timer. Software reaches it through an 8-bit bus. A 16-bit value is written as two bytes: the high byte first, which is parked in a shared holding byte, and then the low byte, which stores all 16 bits at once. In the non-PWM modes the write goes straight into the active compare register. In the PWM modes it goes into a front buffer, and that buffer is copied into the active register only at the count boundary the mode selects (top or bottom). Because of this, a new duty value never produces a pulse of odd length.

On every timer-enable cycle a 16-bit equality check runs between the live count and the active compare value. A match sets a sticky flag for the interrupt controller and acts on a waveform pin, as chosen by a 2-bit action field. In the non-PWM modes software can force a match action on the pin without setting the flag. A write to the counter, reported on an input, hides the match of the next timer-enable cycle. The counter, the mode decoder that produces top and bottom, and the interrupt controller all sit outside this block.

Top module: `ocu16_compare`

## Requirements
- R1: After a synchronous reset, the front buffer, the compare register, the holding byte, the flag and the pin are all 0. Every bus read returns 0.
- R2: A write at address 1 stores only the holding byte and leaves the readable value unchanged. A write at address 0 loads {holding byte, written byte} into the target in that same clock cycle. Reads at address 0 and 1 return the low and high byte of the value software can reach, one cycle after the address is presented.
- R3: When `pwm_mode` is 0, the target of a write is the compare register, and the new value is used for matching from the next cycle on.
- R4: When `pwm_mode` is 1, the target of a write is the front buffer, and reads return the buffer. The buffer is copied into the compare register only on a `tick` cycle where `at_top` is 1 (if `commit_top` is 1) or where `at_bottom` is 1 (if `commit_top` is 0).
- R5: On a `tick` cycle where `count` equals the compare register and the match is not hidden, `cmp_flag` is 1 from the next cycle on. On a `tick` cycle where they differ, the flag is not set.
- R6: A match acts on `oc_pin` according to `com_mode`: 00 leaves it unchanged, 01 toggles it, 10 clears it and 11 sets it.
- R7: Writing 1 to bit 1 at address 2 while `pwm_mode` is 0 applies the R6 action to the pin and leaves the flag unchanged. While `pwm_mode` is 1 this write has no effect. Bit 1 of a read at address 2 is always 0.
- R8: A `cnt_wr` pulse hides the match of the first `tick` cycle after it, even when several cycles without `tick` lie in between. The match of the following `tick` cycle is not hidden.
- R9: The flag stays set until 1 is written to bit 0 at address 2. If a match and a clear fall in the same cycle, the flag is set. Bit 0 of a read at address 2 is the flag.
- R10: While `tick` is 0, no match is taken and no buffer copy happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control/status |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data for the address presented the cycle before |
| pwm_mode | input | 1 | 1 while the timer is in any PWM mode (buffering on) |
| commit_top | input | 1 | 1: copy the buffer at top, 0: copy it at bottom |
| count | input | 16 | Live timer count |
| tick | input | 1 | Timer clock enable |
| at_top | input | 1 | Count is at top this cycle |
| at_bottom | input | 1 | Count is at bottom this cycle |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| com_mode | input | 2 | Pin action on a match |
| oc_pin | output | 1 | Registered waveform pin |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
A bus write takes effect at the rising edge at the end of its cycle. A read value appears one edge after its address is presented. The flag and the pin change at the edge that closes the tick cycle that matched, or the cycle in which the force was written. The bench therefore drives every input at a falling edge, and it samples at the next falling edge for writes, ticks and forces, and one more cycle later for reads. It sweeps counts just below, at and just above several compare values, all pin actions from both pin states, and the two commit points. It also tests hidden matches with a gap of idle cycles before the next tick.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_CLEAR  = 2'b10,
    PIN_SET    = 2'b11
  } pin_act_e;

  localparam int REG_LO  = 0;
  localparam int REG_HI  = 1;
  localparam int REG_CTL = 2;

  localparam int CTL_CLR_BIT   = 0;
  localparam int CTL_FORCE_BIT = 1;
endpackage

// File: rtl/ocu_bus_port.sv
module ocu_bus_port #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  localparam int WIDE_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic              wide_we,
  output logic [WIDE_W-1:0] wide_data,
  output logic              clr_req,
  output logic              force_req
);
  import ocu_pkg::*;

  logic [BUS_W-1:0] hold_q;
  logic             hi_we;
  logic             ctl_we;

  assign hi_we     = bus_we && (bus_addr == ADDR_W'(REG_HI));
  assign ctl_we    = bus_we && (bus_addr == ADDR_W'(REG_CTL));
  assign wide_we   = bus_we && (bus_addr == ADDR_W'(REG_LO));
  assign wide_data = {hold_q, bus_wdata};
  assign clr_req   = ctl_we && bus_wdata[CTL_CLR_BIT];
  assign force_req = ctl_we && bus_wdata[CTL_FORCE_BIT];

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= '0;
    else if (hi_we) hold_q <= bus_wdata;
  end

  // R2: the holding byte changes only on a high-byte write
  assert_hold_only_hi_R2: assert property (@(posedge clk) disable iff (rst)
    !hi_we |=> $stable(hold_q));
endmodule

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwm_mode,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  input  logic         commit_pt,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] buf_q
);
  logic commit;

  assign commit = pwm_mode && tick && commit_pt;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_en && pwm_mode) buf_q <= wr_data;
      if (wr_en && !pwm_mode) cmp_q <= wr_data;
      else if (commit)        cmp_q <= buf_q;
    end
  end

  // R4: the compare register moves only by a direct write or a boundary copy
  assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !pwm_mode) && !commit |=> $stable(cmp_q));
  // R10: without a tick the buffer is never copied
  assert_no_copy_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !tick && !wr_en |=> $stable(cmp_q));
endmodule

// File: rtl/ocu_match_det.sv
module ocu_match_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic         cnt_wr,
  input  logic         flag_clr,
  output logic         match_ev,
  output logic         flag_q
);
  logic blk_q;

  assign match_ev = tick && (count == cmp) && !blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (match_ev)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  // R10: the flag can only rise after a tick cycle
  assert_flag_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));
  // R8: a pending block hides the next tick's match
  assert_block_hides_R8: assert property (@(posedge clk) disable iff (rst)
    blk_q && tick |=> !$rose(flag_q));
  // R9: the flag is sticky until cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    flag_q && !flag_clr |=> flag_q);
endmodule

// File: rtl/ocu_wave_pin.sv
module ocu_wave_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       evt,
  input  logic [1:0] com_mode,
  output logic       pin_q
);
  import ocu_pkg::*;

  pin_act_e act;
  logic     pin_d;

  assign act = pin_act_e'(com_mode);

  always_comb begin
    pin_d = pin_q;
    if (evt) begin
      case (act)
        PIN_TOGGLE: pin_d = ~pin_q;
        PIN_CLEAR:  pin_d = 1'b0;
        PIN_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  // R6: no event or keep action leaves the pin alone
  assert_pin_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !evt || (com_mode == 2'b00) |=> $stable(pin_q));
  // R6: the set action drives the pin high
  assert_pin_set_R6: assert property (@(posedge clk) disable iff (rst)
    evt && (com_mode == 2'b11) |=> pin_q);
endmodule

// File: rtl/ocu16_compare.sv
module ocu16_compare #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              pwm_mode,
  input  logic              commit_top,
  input  logic [CNT_W-1:0]  count,
  input  logic              tick,
  input  logic              at_top,
  input  logic              at_bottom,
  input  logic              cnt_wr,
  input  logic [1:0]        com_mode,
  output logic              oc_pin,
  output logic              cmp_flag
);
  import ocu_pkg::*;

  logic             wide_we;
  logic [CNT_W-1:0] wide_data;
  logic             clr_req;
  logic             force_req;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] buf_val;
  logic [CNT_W-1:0] visible;
  logic             commit_pt;
  logic             match_ev;
  logic             force_ev;
  logic             pin_evt;

  ocu_bus_port #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wide_we(wide_we), .wide_data(wide_data),
    .clr_req(clr_req), .force_req(force_req)
  );

  assign commit_pt = commit_top ? at_top : at_bottom;

  ocu_cmp_store #(.W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .pwm_mode(pwm_mode), .wr_en(wide_we),
    .wr_data(wide_data), .tick(tick), .commit_pt(commit_pt),
    .cmp_q(cmp_val), .buf_q(buf_val)
  );

  ocu_match_det #(.W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .tick(tick), .count(count), .cmp(cmp_val),
    .cnt_wr(cnt_wr), .flag_clr(clr_req), .match_ev(match_ev),
    .flag_q(cmp_flag)
  );

  assign force_ev = force_req && !pwm_mode;
  assign pin_evt  = match_ev || force_ev;

  ocu_wave_pin u_pin (
    .clk(clk), .rst(rst), .evt(pin_evt), .com_mode(com_mode), .pin_q(oc_pin)
  );

  assign visible = pwm_mode ? buf_val : cmp_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (int'(bus_addr))
        REG_LO:  bus_rdata <= visible[BUS_W-1:0];
        REG_HI:  bus_rdata <= visible[CNT_W-1:BUS_W];
        REG_CTL: bus_rdata <= {{(BUS_W-1){1'b0}}, cmp_flag};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R7: a force write in PWM mode without a match leaves the pin alone
  assert_force_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    force_req && pwm_mode && !match_ev |=> $stable(oc_pin));
  // R7: a force never sets the flag on its own
  assert_force_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    force_ev && !match_ev && !cmp_flag |=> !cmp_flag);
endmodule

// File: tb/test_ocu16_compare.sv
module test_ocu16_compare;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        pwm_mode, commit_top, tick, at_top, at_bottom, cnt_wr;
  logic [15:0] count;
  logic [1:0]  com_mode;
  logic        oc_pin, cmp_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic exp_pin;

  always #2.5 clk = ~clk;

  ocu16_compare i_ocu16_compare (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_mode(pwm_mode),
    .commit_top(commit_top), .count(count), .tick(tick), .at_top(at_top),
    .at_bottom(at_bottom), .cnt_wr(cnt_wr), .com_mode(com_mode),
    .oc_pin(oc_pin), .cmp_flag(cmp_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd8(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd8(2'd0, lo);
    rd8(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic set16(input logic [15:0] v);
    wr(2'd1, v[15:8]);
    wr(2'd0, v[7:0]);
  endtask

  task automatic pulse(input logic [15:0] c, input logic t, input logic b);
    @(negedge clk);
    count = c; tick = 1'b1; at_top = t; at_bottom = b;
    @(negedge clk);
    tick = 1'b0; at_top = 1'b0; at_bottom = 1'b0;
  endtask

  task automatic clear_flag();
    wr(2'd2, 8'h01);
  endtask

  function automatic logic pin_model(input logic [1:0] m, input logic p);
    case (m)
      2'b01:   return ~p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [15:0] cmps [5];
    cmps[0] = 16'h0000; cmps[1] = 16'h1234; cmps[2] = 16'hFFFF;
    cmps[3] = 16'h00FF; cmps[4] = 16'hFF00;

    rst = 1'b1; bus_we = 0; bus_addr = 0; bus_wdata = 0; pwm_mode = 0;
    commit_top = 1; tick = 0; at_top = 0; at_bottom = 0; cnt_wr = 0;
    count = 16'h5555; com_mode = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(cmp_flag == 0, "R1 flag", cmp_flag, 0);
    check(oc_pin == 0, "R1 pin", oc_pin, 0);
    rd16(v);
    check(v == 0, "R1 compare read", v, 0);
    rd8(2'd2, b);
    check(b == 0, "R1 status read", b, 0);

    // R2 high byte alone does not reach the target, low byte loads both
    wr(2'd1, 8'h12);
    rd16(v);
    check(v == 16'h0000, "R2 high-only write", v, 0);
    wr(2'd0, 8'h34);
    rd16(v);
    check(v == 16'h1234, "R2 paired write", v, 16'h1234);

    // R3/R5 sweep around several compare values, non-PWM
    foreach (cmps[i]) begin
      set16(cmps[i]);
      rd16(v);
      check(v == cmps[i], "R3 direct write", v, cmps[i]);
      for (int d = -2; d <= 2; d++) begin
        logic [15:0] c;
        c = 16'(int'(cmps[i]) + d);
        pulse(c, 1'b0, 1'b0);
        check(cmp_flag == (d == 0), "R5 match flag", cmp_flag, d == 0);
        check(oc_pin == 0, "R6 keep action", oc_pin, 0);
        if (cmp_flag) begin
          clear_flag();
          check(cmp_flag == 0, "R9 clear", cmp_flag, 0);
        end
      end
    end

    // R10 no match without tick
    set16(16'h1234);
    @(negedge clk); count = 16'h1234;
    repeat (3) @(negedge clk);
    check(cmp_flag == 0, "R10 idle no match", cmp_flag, 0);

    // R9 sticky and set-over-clear
    pulse(16'h1234, 0, 0);
    pulse(16'h0001, 0, 0);
    check(cmp_flag == 1, "R9 sticky", cmp_flag, 1);
    clear_flag();
    @(negedge clk);
    count = 16'h1234; tick = 1; bus_we = 1; bus_addr = 2'd2; bus_wdata = 8'h01;
    @(negedge clk);
    tick = 0; bus_we = 0;
    check(cmp_flag == 1, "R9 set beats clear", cmp_flag, 1);
    rd8(2'd2, b);
    check(b == 8'h01, "R9 status bit", b, 1);
    clear_flag();

    // R6 all pin actions from both states via matches
    exp_pin = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        com_mode = 2'(m);
        pulse(16'h1234, 0, 0);
        exp_pin = pin_model(2'(m), exp_pin);
        check(oc_pin == exp_pin, "R6 match action", oc_pin, exp_pin);
        clear_flag();
      end
      com_mode = 2'b01;
      pulse(16'h1234, 0, 0);
      exp_pin = ~exp_pin;
      clear_flag();
    end

    // R7 force in non-PWM mode
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        com_mode = 2'(m);
        wr(2'd2, 8'h02);
        exp_pin = pin_model(2'(m), exp_pin);
        check(oc_pin == exp_pin, "R7 force action", oc_pin, exp_pin);
        check(cmp_flag == 0, "R7 force no flag", cmp_flag, 0);
      end
    end
    rd8(2'd2, b);
    check(b == 8'h00, "R7 force reads zero", b, 0);

    // R8 counter write hides the next tick match, after idle cycles
    com_mode = 2'b00;
    set16(16'h0400);
    @(negedge clk); count = 16'h0400; cnt_wr = 1;
    @(negedge clk); cnt_wr = 0;
    repeat (3) @(negedge clk);
    check(cmp_flag == 0, "R8 stopped no flag", cmp_flag, 0);
    pulse(16'h0400, 0, 0);
    check(cmp_flag == 0, "R8 hidden match", cmp_flag, 0);
    pulse(16'h0400, 0, 0);
    check(cmp_flag == 1, "R8 next match seen", cmp_flag, 1);
    clear_flag();

    // R7 force ignored in PWM mode
    pwm_mode = 1; com_mode = 2'b01;
    exp_pin = oc_pin;
    wr(2'd2, 8'h02);
    check(oc_pin == exp_pin, "R7 force ignored in PWM", oc_pin, exp_pin);
    com_mode = 2'b00;

    // R4 buffered write, commit at top
    commit_top = 1;
    set16(16'h0500);
    rd16(v);
    check(v == 16'h0500, "R4 buffer read", v, 16'h0500);
    pulse(16'h0500, 0, 0);
    check(cmp_flag == 0, "R4 buffer not active", cmp_flag, 0);
    pulse(16'h0400, 0, 0);
    check(cmp_flag == 1, "R4 old compare active", cmp_flag, 1);
    clear_flag();
    pulse(16'h0001, 0, 1);
    pulse(16'h0500, 0, 0);
    check(cmp_flag == 0, "R4 bottom ignored when top chosen", cmp_flag, 0);
    pulse(16'hFFFF, 1, 0);
    pulse(16'h0500, 0, 0);
    check(cmp_flag == 1, "R4 copy at top", cmp_flag, 1);
    clear_flag();

    // R4/R10 commit at bottom, needs tick
    commit_top = 0;
    set16(16'h0600);
    @(negedge clk); count = 16'h0000; at_bottom = 1;
    @(negedge clk); at_bottom = 0;
    pulse(16'h0600, 0, 0);
    check(cmp_flag == 0, "R10 no copy without tick", cmp_flag, 0);
    pulse(16'h0000, 0, 1);
    pulse(16'h0600, 0, 0);
    check(cmp_flag == 1, "R4 copy at bottom", cmp_flag, 1);
    clear_flag();

    // R3 back to direct mode reads the compare register
    pwm_mode = 0;
    rd16(v);
    check(v == 16'h0600, "R3 compare read", v, 16'h0600);

    done = 1'b1;
    report();
  end
endmodule